// File: doc/BRIEF.md
# Claim-Gated Memory Copy Channel

This block is one channel of a memory-to-memory copy engine. Software programs a source address, a destination address, a byte count and a transaction size into a set of staging registers. It then starts the job through a control word. The channel reads a chunk from the source, writes the same chunk to the destination, and repeats until the count is used up. When the job ends it raises a done flag, and an interrupt if that is enabled.

A job can only start on a channel that software has already taken. Taking the channel, which means moving the claim bit from 0 to 1, wipes the staging registers, so a new owner never inherits an old job. The engine copies working versions of the staging values at start, so the staging registers read back unchanged after a job.

On the memory port, data is packed from the addressed byte upward. Byte lane 0 of the data bus belongs to `mem_addr`, lane 1 to `mem_addr+1`, and so on. The byte enables therefore always form a run of ones starting at bit 0. A request is held until the memory answers it with `mem_ack`, and `mem_err` is sampled in the same cycle as that acknowledge.

Top module: `dma_chan`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. The register offsets are:
  - 0x00: control.
  - 0x04: configuration. Read size is in bits 31:28 and write size in bits 27:24.
  - 0x08 and 0x0C: byte count, low and high word.
  - 0x10 and 0x14: destination address, low and high word.
  - 0x18 and 0x1C: source address, low and high word.
- R2: The control bit positions are claim at bit 0, run at bit 1, interrupt enable at bit 14, done at bit 30 and error at bit 31. A control write that moves claim from 0 to 1 clears the configuration, count, destination and source registers. A control write while claim is already 1 leaves them unchanged.
- R3: Run is honoured only if claim was already 1 before the control write. A control write of 0x3 on a released channel claims the channel but issues no memory access, and control then reads 0x00000001.
- R4: A job started with a byte count of 0 issues no memory access. It sets done, leaves error clear and clears run.
- R5: Each transaction moves 2^n bytes, where n is the smallest of the read size, the write size and log2 of the bus width in bytes. The last transaction is trimmed to the bytes that remain, and the byte enables are ones in bits 0 up to count-1. No destination byte beyond the count is written.
- R6: Transactions run in increasing address order, each a read of the source followed by a write of the destination. After the job, the staging registers read back the values they held when the job started.
- R7: Run clears by itself when the job ends, and done is then set. `irq` equals done AND interrupt enable.
- R8: While a job is active, writes to the staging registers and to the claim bit are ignored.
- R9: An access that returns `mem_err` ends the job. It sets the error bit, leaves done clear and issues no further access.
- R10: Writing 0 to done or to error clears that flag, and writing 1 keeps it. Starting a new job clears both flags.
- R11: Once raised, `mem_req` stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address of lane 0 |
| mem_wdata | output | 8*DATA_BYTES | Write data, packed from lane 0 |
| mem_be | output | DATA_BYTES | Byte enables |
| mem_rdata | input | 8*DATA_BYTES | Read data, packed from lane 0 |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Error response, valid with mem_ack |
| irq | output | 1 | Done interrupt |

## Verification
Two events can land on the same clock edge. In the first, a zero-length job starts and ends in one cycle, so the start clears done while the finish sets it. The bench provokes this with a zero-count run and expects done set, error clear and no bus access. In the second, a register write arrives in the cycle right after a job starts. The bench writes the count register while the engine is busy and judges the result by the final copy and by the count read back afterwards. A per-transaction reference queue built from the requirements checks every write's address and byte enables as it happens.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [4:0] OFF_CTRL   = 5'h00;
  localparam logic [4:0] OFF_CFG    = 5'h04;
  localparam logic [4:0] OFF_LEN_LO = 5'h08;
  localparam logic [4:0] OFF_LEN_HI = 5'h0C;
  localparam logic [4:0] OFF_DST_LO = 5'h10;
  localparam logic [4:0] OFF_DST_HI = 5'h14;
  localparam logic [4:0] OFF_SRC_LO = 5'h18;
  localparam logic [4:0] OFF_SRC_HI = 5'h1C;

  localparam int BIT_CLAIM = 0;
  localparam int BIT_RUN   = 1;
  localparam int BIT_IE    = 14;
  localparam int BIT_DONE  = 30;
  localparam int BIT_ERR   = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        fin,
  input  logic        fin_err,
  output logic [31:0] rdata,
  output logic        start,
  output logic        claim_q,
  output logic        ie_q,
  output logic        done_q,
  output logic        err_q,
  output logic [3:0]  rsz_q,
  output logic [3:0]  wsz_q,
  output logic [63:0] len_q,
  output logic [63:0] dst_q,
  output logic [63:0] src_q
);
  logic        claim_d, ie_d, done_d, err_d;
  logic [3:0]  rsz_d, wsz_d;
  logic [63:0] len_d, dst_d, src_d;
  logic        ctrl_wr, grab, stage_wr;

  assign ctrl_wr  = wr_en && (addr == OFF_CTRL);
  assign grab     = ctrl_wr && !busy && wdata[BIT_CLAIM] && !claim_q;
  assign start    = ctrl_wr && !busy && wdata[BIT_RUN] && claim_q;
  assign stage_wr = wr_en && !busy;

  always_comb begin
    claim_d = claim_q;
    ie_d    = ie_q;
    done_d  = done_q;
    err_d   = err_q;
    rsz_d   = rsz_q;
    wsz_d   = wsz_q;
    len_d   = len_q;
    dst_d   = dst_q;
    src_d   = src_q;
    if (ctrl_wr) begin
      if (!busy) claim_d = wdata[BIT_CLAIM];
      ie_d   = wdata[BIT_IE];
      done_d = done_q & wdata[BIT_DONE];
      err_d  = err_q & wdata[BIT_ERR];
    end
    if (start) begin
      done_d = 1'b0;
      err_d  = 1'b0;
    end
    if (fin) begin
      if (fin_err) err_d = 1'b1;
      else         done_d = 1'b1;
    end
    if (grab) begin
      rsz_d = '0; wsz_d = '0; len_d = '0; dst_d = '0; src_d = '0;
    end else if (stage_wr) begin
      case (addr)
        OFF_CFG:    begin rsz_d = wdata[31:28]; wsz_d = wdata[27:24]; end
        OFF_LEN_LO: len_d[31:0]  = wdata;
        OFF_LEN_HI: len_d[63:32] = wdata;
        OFF_DST_LO: dst_d[31:0]  = wdata;
        OFF_DST_HI: dst_d[63:32] = wdata;
        OFF_SRC_LO: src_d[31:0]  = wdata;
        OFF_SRC_HI: src_d[63:32] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0; ie_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      rsz_q <= '0; wsz_q <= '0; len_q <= '0; dst_q <= '0; src_q <= '0;
    end else begin
      claim_q <= claim_d; ie_q <= ie_d; done_q <= done_d; err_q <= err_d;
      rsz_q <= rsz_d; wsz_q <= wsz_d; len_q <= len_d; dst_q <= dst_d; src_q <= src_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_CTRL: begin
        rdata[BIT_CLAIM] = claim_q;
        rdata[BIT_RUN]   = busy;
        rdata[BIT_IE]    = ie_q;
        rdata[BIT_DONE]  = done_q;
        rdata[BIT_ERR]   = err_q;
      end
      OFF_CFG:    rdata = {rsz_q, wsz_q, 24'h0};
      OFF_LEN_LO: rdata = len_q[31:0];
      OFF_LEN_HI: rdata = len_q[63:32];
      OFF_DST_LO: rdata = dst_q[31:0];
      OFF_DST_HI: rdata = dst_q[63:32];
      OFF_SRC_LO: rdata = src_q[31:0];
      OFF_SRC_HI: rdata = src_q[63:32];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int DATA_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [63:0]             len,
  input  logic [63:0]             dst,
  input  logic [63:0]             src,
  input  logic [3:0]              rsz,
  input  logic [3:0]              wsz,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [63:0]             mem_addr,
  output logic [8*DATA_BYTES-1:0] mem_wdata,
  output logic [DATA_BYTES-1:0]   mem_be,
  input  logic [8*DATA_BYTES-1:0] mem_rdata,
  input  logic                    mem_ack,
  input  logic                    mem_err,
  output logic                    busy,
  output logic                    fin,
  output logic                    fin_err
);
  localparam int LG_DB = $clog2(DATA_BYTES);
  localparam int CW    = LG_DB + 1;

  eng_st_e                 st_q, st_d;
  logic [63:0]             rem_q, rem_d, sp_q, sp_d, dp_q, dp_d;
  logic [3:0]              rsz_q, rsz_d, wsz_q, wsz_d;
  logic [8*DATA_BYTES-1:0] buf_q, buf_d;
  logic [3:0]              lg;
  logic [63:0]             full;
  logic [CW-1:0]           cnt;

  always_comb begin
    lg = (rsz_q < wsz_q) ? rsz_q : wsz_q;
    if (lg > 4'(LG_DB)) lg = 4'(LG_DB);
    full = 64'd1 << lg;
    cnt  = (rem_q < full) ? rem_q[CW-1:0] : full[CW-1:0];
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_be
    assign mem_be[i] = (CW'(i) < cnt);
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? dp_q : sp_q;
  assign mem_wdata = buf_q;

  always_comb begin
    st_d = st_q; rem_d = rem_q; sp_d = sp_q; dp_d = dp_q;
    rsz_d = rsz_q; wsz_d = wsz_q; buf_d = buf_q;
    fin = 1'b0; fin_err = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (len == 64'd0) begin
          fin = 1'b1;
        end else begin
          st_d = ST_RD; rem_d = len; sp_d = src; dp_d = dst;
          rsz_d = rsz; wsz_d = wsz;
        end
      end
      ST_RD: if (mem_ack) begin
        if (mem_err) begin
          fin = 1'b1; fin_err = 1'b1; st_d = ST_IDLE;
        end else begin
          buf_d = mem_rdata; st_d = ST_WR;
        end
      end
      ST_WR: if (mem_ack) begin
        if (mem_err) begin
          fin = 1'b1; fin_err = 1'b1; st_d = ST_IDLE;
        end else begin
          rem_d = rem_q - 64'(cnt);
          sp_d  = sp_q + 64'(cnt);
          dp_d  = dp_q + 64'(cnt);
          if (rem_q == 64'(cnt)) begin
            fin = 1'b1; st_d = ST_IDLE;
          end else begin
            st_d = ST_RD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rem_q <= '0; sp_q <= '0; dp_q <= '0;
      rsz_q <= '0; wsz_q <= '0; buf_q <= '0;
    end else begin
      st_q <= st_d; rem_q <= rem_d; sp_q <= sp_d; dp_q <= dp_d;
      rsz_q <= rsz_d; wsz_q <= wsz_d; buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int DATA_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [4:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [63:0]             mem_addr,
  output logic [8*DATA_BYTES-1:0] mem_wdata,
  output logic [DATA_BYTES-1:0]   mem_be,
  input  logic [8*DATA_BYTES-1:0] mem_rdata,
  input  logic                    mem_ack,
  input  logic                    mem_err,
  output logic                    irq
);
  logic        start, busy, fin, fin_err;
  logic        claim_q, ie_q, done_q, err_q;
  logic [3:0]  rsz_q, wsz_q;
  logic [63:0] len_q, dst_q, src_q;

  dma_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .fin(fin), .fin_err(fin_err), .rdata(reg_rdata), .start(start),
    .claim_q(claim_q), .ie_q(ie_q), .done_q(done_q), .err_q(err_q),
    .rsz_q(rsz_q), .wsz_q(wsz_q), .len_q(len_q), .dst_q(dst_q), .src_q(src_q)
  );

  dma_chan_engine #(.DATA_BYTES(DATA_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len_q), .dst(dst_q), .src(src_q),
    .rsz(rsz_q), .wsz(wsz_q), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .busy(busy), .fin(fin), .fin_err(fin_err)
  );

  assign irq = done_q & ie_q;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int DATA_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic [63:0]           mem_addr,
  input logic [DATA_BYTES-1:0] mem_be,
  input logic                  mem_ack,
  input logic                  mem_err,
  input logic                  irq,
  input logic                  claim,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic                  start,
  input logic [63:0]           len
);
  p_req_claimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> claim);

  p_be_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != '0) &&
      ((({1'b0, mem_be} + 1'b1) & {1'b0, mem_be}) == '0));

  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len == 64'd0) |=> (done && !err && !mem_req));

  p_run_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  p_irq_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (!busy && err && !mem_req));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind dma_chan dma_chan_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq), .claim(claim_q),
  .busy(busy), .done(done_q), .err(err_q), .start(start), .len(len_q)
);

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;
  localparam int DB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req, mem_we;
  logic [63:0]   mem_addr;
  logic [8*DB-1:0] mem_wdata, mem_rdata;
  logic [DB-1:0] mem_be;
  logic          mem_ack, mem_err;
  logic          irq;

  int n_chk = 0, n_fail = 0, n_acc = 0;
  logic [7:0]  mem [4096];
  logic [63:0] exp_a [$];
  logic [DB-1:0] exp_b [$];

  always #4 clk = ~clk;

  dma_chan #(.DATA_BYTES(DB)) u_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench memory: acknowledges one negedge after a request, errors in 0xF00..0xFFF
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end else if (mem_req) begin
      n_acc++;
      mem_ack <= 1'b1;
      mem_err <= (mem_addr[11:8] == 4'hF);
      if (mem_we) begin
        n_chk++;
        if (exp_a.size() == 0) begin
          n_fail++;
          $display("FAIL R6 unexpected write actual=%0h expected=none", mem_addr);
        end else begin
          logic [63:0] ea;
          logic [DB-1:0] eb;
          ea = exp_a.pop_front();
          eb = exp_b.pop_front();
          if (ea !== mem_addr || eb !== mem_be) begin
            n_fail++;
            $display("FAIL R5 write actual=%0h/%0h expected=%0h/%0h", mem_addr, mem_be, ea, eb);
          end
        end
        for (int b = 0; b < DB; b++)
          if (mem_be[b]) mem[(mem_addr[11:0] + 12'(b))] = mem_wdata[8*b +: 8];
      end else begin
        for (int b = 0; b < DB; b++) mem_rdata[8*b +: 8] <= mem[(mem_addr[11:0] + 12'(b))];
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h00, c);
      if (!c[1]) return;
      @(negedge clk);
    end
    check("R7 run never cleared", 1, 0);
  endtask

  task automatic prep(input int src, input int dst, input int len, input int rs, input int ws);
    int lg, off, c;
    for (int i = 0; i < 64; i++) begin
      mem[(src + i) % 4096] = 8'(i * 7 + 3);
      mem[(dst + i) % 4096] = 8'hEE;
    end
    wr(5'h04, {4'(rs), 4'(ws), 24'h0});
    wr(5'h08, len); wr(5'h0C, 0);
    wr(5'h10, dst); wr(5'h14, 0);
    wr(5'h18, src); wr(5'h1C, 0);
    lg = (rs < ws) ? rs : ws;
    if (lg > 3) lg = 3;
    off = 0;
    while (off < len) begin
      c = ((len - off) < (1 << lg)) ? (len - off) : (1 << lg);
      exp_a.push_back(64'(dst + off));
      exp_b.push_back(DB'((1 << c) - 1));
      off += c;
    end
  endtask

  task automatic copy_ok(input string req, input int src, input int dst, input int len);
    int bad = 0;
    for (int i = 0; i < len; i++) if (mem[dst + i] !== mem[src + i]) bad++;
    check(req, bad, 0);
    check(req, mem[dst + len], 8'hEE);
    check(req, exp_a.size(), 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int acc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h00, d); check("R1 ctrl reset", d, 0);
    rd(5'h08, d); check("R1 len reset", d, 0);
    check("R1 irq reset", irq, 0);

    // R2 claim and clearing of staging registers
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h55);
    rd(5'h08, d); check("R1 len readback", d, 32'h55);
    wr(5'h00, 32'h1);
    rd(5'h08, d); check("R2 reclaim keeps", d, 32'h55);
    wr(5'h04, 32'h3300_0000);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h9);
    // R3 run on released channel: claims, clears, no access
    acc0 = n_acc;
    wr(5'h00, 32'h3);
    repeat (4) @(negedge clk);
    check("R3 no access", n_acc - acc0, 0);
    rd(5'h00, d); check("R3 ctrl", d, 32'h1);
    rd(5'h08, d); check("R2 len cleared", d, 0);
    rd(5'h04, d); check("R2 cfg cleared", d, 0);

    // R4 zero length with interrupt enable
    acc0 = n_acc;
    wr(5'h00, 32'h4003);
    @(negedge clk);
    rd(5'h00, d); check("R4 ctrl", d, 32'h4000_4001);
    check("R4 no access", n_acc - acc0, 0);
    check("R7 irq", irq, 1);
    wr(5'h00, 32'h4001);
    rd(5'h00, d); check("R10 done cleared", d, 32'h4001);
    check("R10 irq low", irq, 0);

    // R5 three bytes with two-byte transactions
    prep(12'h100, 12'h200, 3, 1, 1);
    wr(5'h00, 32'h3);
    wait_idle();
    copy_ok("R5 trimmed", 12'h100, 12'h200, 3);
    rd(5'h00, d); check("R7 done", d, 32'h4000_0001);

    // R6 full 8-byte chunks, staging unchanged afterwards
    prep(12'h300, 12'h400, 32, 5, 3);
    wr(5'h00, 32'h3);
    wait_idle();
    copy_ok("R6 copy", 12'h300, 12'h400, 32);
    rd(5'h08, d); check("R6 len kept", d, 32);
    rd(5'h18, d); check("R6 src kept", d, 32'h300);

    // R5 13 bytes, 4-byte chunks
    prep(12'h500, 12'h600, 13, 2, 3);
    wr(5'h00, 32'h3);
    wait_idle();
    copy_ok("R5 partial", 12'h500, 12'h600, 13);

    // R8 staging write while busy ignored
    prep(12'h700, 12'h800, 24, 3, 3);
    wr(5'h00, 32'h3);
    wr(5'h08, 32'h5);
    wr(5'h00, 32'h2);
    wait_idle();
    copy_ok("R8 copy", 12'h700, 12'h800, 24);
    rd(5'h08, d); check("R8 len ignored", d, 24);
    rd(5'h00, d); check("R8 claim kept", d[0], 1);

    // R9 bus error on source
    acc0 = n_acc;
    wr(5'h04, 32'h3300_0000);
    wr(5'h08, 16); wr(5'h18, 12'hF00); wr(5'h10, 12'h900);
    wr(5'h00, 32'h3);
    wait_idle();
    check("R9 one access", n_acc - acc0, 1);
    rd(5'h00, d); check("R9 ctrl", d, 32'h8000_0001);
    // R10 new run clears error
    prep(12'hA00, 12'hB00, 8, 3, 3);
    wr(5'h00, 32'h3);
    wait_idle();
    rd(5'h00, d); check("R10 err cleared", d, 32'h4000_0001);
    copy_ok("R10 copy", 12'hA00, 12'hB00, 8);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule